// File: doc/BRIEF.md
# Timestamp-Referenced Lock-In Demodulator

This block demodulates batches of sixteen signed 16-bit ADC samples against a reference that is known only by the edge times it produces. A fast counter captures the reference's rising edges. The counter is taken to read zero at the first sample of each batch. The block keeps the two most recent captures and moves them onto each new batch's time base. From those captures it gets the reference period and the phase of every sample. Each sample is then multiplied by the sine and the cosine of its phase.

During a batch the user streams edge captures (`ts_valid`) and samples (`smp_valid`) in while `busy` is low, then pulses `batch_end`. The block then works through the sixteen samples in order. For each one it emits a pair of 32-bit products with its index. If fewer than two edge times are known, it emits a single `batch_err` pulse and no products. The phase offset, the sample period in counter ticks and the harmonic multiplier are run-time configuration inputs. Phases are held as 16-bit fractions of a turn.

Top module: `lockin_demod`

## Requirements
- R1: A `batch_end` that finds two valid edge times yields exactly sixteen `out_valid` pulses, with `out_idx` counting 0 through 15. Sample k is the k-th sample accepted since the previous `batch_end`.
- R2: Two edge slots, newer and older, each with a valid bit. Pushing a capture moves the newer slot into the older one and loads the capture into the newer one. A slot never loses its valid bit except on reset.
- R3: At each `batch_end`, before any push, every valid slot is reduced by 16 × `cfg_period`.
- R4: Of the captures delivered since the previous `batch_end`, only the last two are pushed, in arrival order. Earlier ones have no effect on the products.
- R5: If either slot is still empty after the update, the block gives one `batch_err` pulse and no `out_valid` pulse for that batch.
- R6: The reference period is R = newer − older. The integer phase is p = (k × `cfg_period` − newer) × `cfg_harm`. The phase fraction is f = ⌊|p|·2^16 / R⌋ mod 2^16, negated modulo 2^16 when p < 0. The sample phase is (`cfg_offset` + f) mod 2^16, where 2^16 is one turn.
- R7: sin(φ) takes quadrant q = φ[15:14] and index i = φ[13:8], with k = i for even q and 63 − i for odd q. Its value is round(32767·sin(π(2k+1)/256)), negated when q ≥ 2. cos(φ) is sin(φ + 0x4000).
- R8: `out_i` = sin(φ)·sample and `out_q` = cos(φ)·sample, both as signed 32-bit values.
- R9: Reset empties both slots and holds `busy`, `out_valid` and `batch_err` low.
- R10: `busy` is high from the cycle after an accepted `batch_end` until the batch's last product or its error has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_offset | input | 16 | Phase offset as a fraction of a turn |
| cfg_period | input | 16 | ADC sample period in counter ticks |
| cfg_harm | input | 8 | Harmonic multiplier |
| ts_valid | input | 1 | Edge capture strobe (taken while idle) |
| ts_value | input | 16 | Edge capture counter value |
| smp_valid | input | 1 | Sample strobe (taken while idle) |
| smp_data | input | 16 | Signed ADC sample |
| batch_end | input | 1 | Closes the batch and starts processing |
| busy | output | 1 | Processing in progress |
| batch_err | output | 1 | Batch rejected for lack of edge times |
| out_valid | output | 1 | Product pair valid |
| out_idx | output | 4 | Sample index of the pair |
| out_i | output | 32 | sin × sample |
| out_q | output | 32 | cos × sample |

## Verification
The bench runs batches with no edge, with one edge, and with three edges. A design that pushed every capture, or the first two, would then compute a different period and phase. It also runs a batch with no new edge, where only aging keeps the old slots usable. A block that forgot to age the slots, or aged them twice, would show phase errors on every sample. Other batches make the integer phase negative, use harmonic 3 with an offset, and use full-scale samples of both signs. These catch a wrong sign fold in the phase and a wrong quadrant fold in the table. A reset between batches must bring the error back; a block that kept stale slots would emit products instead.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
  localparam int SMP_W  = 16;
  localparam int TS_W   = 16;
  localparam int SLOT_W = 32;
  localparam int PH_W   = 16;
  localparam int HARM_W = 8;
  localparam int BATCH  = 16;
  localparam int LUT_AW = 6;
  localparam int IDX_W  = $clog2(BATCH);
  localparam int IP_W   = SLOT_W + HARM_W + 2;
  localparam int DVD_W  = IP_W + PH_W;
  localparam int PROD_W = 2 * SMP_W;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_START, S_DIV, S_MUL} lk_state_e;

  // Quarter-wave entry k: round(32767*sin(pi*(2k+1)/2^(aw+2))), Q30 Taylor series.
  function automatic int quarter_sine(int k, int aw);
    longint pi_q30, x, x2, term, acc;
    pi_q30 = 64'sd3373259426;
    x      = (pi_q30 * longint'(2 * k + 1)) >>> (aw + 2);
    x2     = (x * x) >>> 30;
    term   = x;
    acc    = x;
    for (int j = 1; j < 8; j++) begin
      term = -(((term * x2) >>> 30) / longint'(2 * j * (2 * j + 1)));
      acc  = acc + term;
    end
    return int'((acc * 32767 + (longint'(1) <<< 29)) >>> 30);
  endfunction
endpackage

// File: rtl/lockin_ts_track.sv
module lockin_ts_track
  import lockin_pkg::*;
#(
  parameter int TSW = TS_W,
  parameter int SW  = SLOT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ts_valid,
  input  logic [TSW-1:0]       ts_value,
  input  logic                 batch_end,
  input  logic [SW-1:0]        age_step,
  output logic signed [SW-1:0] newest,
  output logic signed [SW-1:0] oldest,
  output logic                 both_valid
);
  logic signed [SW-1:0] new_q, new_d, old_q, old_d, p1_q, p1_d, p0_q, p0_d;
  logic                 vn_q, vn_d, vo_q, vo_d;
  logic [1:0]           pc_q, pc_d;
  logic signed [SW-1:0] new_aged, old_aged;

  assign new_aged = new_q - $signed(age_step);
  assign old_aged = old_q - $signed(age_step);

  always_comb begin
    new_d = new_q; old_d = old_q; vn_d = vn_q; vo_d = vo_q;
    p1_d  = p1_q;  p0_d  = p0_q;  pc_d = pc_q;
    if (batch_end) begin
      pc_d = 2'd0;
      unique case (pc_q)
        2'd0: begin
          new_d = vn_q ? new_aged : new_q;
          old_d = vo_q ? old_aged : old_q;
        end
        2'd1: begin
          old_d = new_aged; vo_d = vn_q;
          new_d = p1_q;     vn_d = 1'b1;
        end
        default: begin
          old_d = p0_q; vo_d = 1'b1;
          new_d = p1_q; vn_d = 1'b1;
        end
      endcase
    end else if (ts_valid) begin
      p1_d = SW'(ts_value);
      p0_d = p1_q;
      if (pc_q != 2'd2) pc_d = pc_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= '0; old_q <= '0; p1_q <= '0; p0_q <= '0;
      vn_q  <= 1'b0; vo_q <= 1'b0; pc_q <= 2'd0;
    end else begin
      new_q <= new_d; old_q <= old_d; p1_q <= p1_d; p0_q <= p0_d;
      vn_q  <= vn_d;  vo_q  <= vo_d;  pc_q <= pc_d;
    end
  end

  assign newest     = new_q;
  assign oldest     = old_q;
  assign both_valid = vn_q & vo_q;

  p_two_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_end && pc_q == 2'd2) |=> (vn_q && vo_q));
  p_valid_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_end && vn_q) |=> vn_q);
  p_age_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (batch_end && pc_q == 2'd0 && vn_q) |=> (new_q == $past(new_q) - $signed($past(age_step))));
endmodule

// File: rtl/lockin_div.sv
module lockin_div #(
  parameter int DVD_W = 58,
  parameter int DVS_W = 32,
  parameter int Q_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             done,
  output logic [Q_W-1:0]   quotient
);
  localparam int CNT_W = $clog2(DVD_W);

  logic [DVD_W-1:0] q_q, q_d;
  logic [DVS_W-1:0] r_q, r_d;
  logic [CNT_W-1:0] c_q, c_d;
  logic             run_q, run_d, done_q, done_d;
  logic [DVS_W:0]   trial;
  logic             ge;

  assign trial = {r_q, q_q[DVD_W-1]};
  assign ge    = (trial >= {1'b0, divisor});

  always_comb begin
    q_d = q_q; r_d = r_q; c_d = c_q; run_d = run_q; done_d = 1'b0;
    if (start) begin
      q_d = dividend; r_d = '0; c_d = CNT_W'(DVD_W - 1); run_d = 1'b1;
    end else if (run_q) begin
      q_d = {q_q[DVD_W-2:0], ge};
      r_d = ge ? DVS_W'(trial - {1'b0, divisor}) : trial[DVS_W-1:0];
      if (c_q == '0) begin
        run_d = 1'b0; done_d = 1'b1;
      end else begin
        c_d = c_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= '0; r_q <= '0; c_q <= '0; run_q <= 1'b0; done_q <= 1'b0;
    end else begin
      q_q <= q_d; r_q <= r_d; c_q <= c_d; run_q <= run_d; done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign quotient = q_q[Q_W-1:0];

  logic unused_q_hi;
  assign unused_q_hi = ^q_q[DVD_W-1:Q_W];

  p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && divisor != '0) |-> (r_q < divisor));
endmodule

// File: rtl/lockin_sincos.sv
module lockin_sincos
  import lockin_pkg::*;
#(
  parameter int AW = LUT_AW,
  parameter int OW = SMP_W
) (
  input  logic [AW+1:0]        ph_hi,
  output logic signed [OW-1:0] sin_o,
  output logic signed [OW-1:0] cos_o
);
  localparam int DEPTH = 1 << AW;

  logic [OW-2:0]        rom [DEPTH];
  logic signed [OW-1:0] val [2];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    localparam int V = quarter_sine(g, AW);
    assign rom[g] = (OW-1)'(V);
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [AW+1:0] p;
    logic [AW-1:0] k;
    logic [OW-1:0] mag;
    assign p      = (c == 0) ? ph_hi : ph_hi + (AW+2)'(DEPTH);
    assign k      = p[AW] ? ~p[AW-1:0] : p[AW-1:0];
    assign mag    = {1'b0, rom[k]};
    assign val[c] = p[AW+1] ? -$signed(mag) : $signed(mag);
  end

  assign sin_o = val[0];
  assign cos_o = val[1];
endmodule

// File: rtl/lockin_demod.sv
module lockin_demod
  import lockin_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PH_W-1:0]          cfg_offset,
  input  logic [15:0]              cfg_period,
  input  logic [HARM_W-1:0]        cfg_harm,
  input  logic                     ts_valid,
  input  logic [TS_W-1:0]          ts_value,
  input  logic                     smp_valid,
  input  logic signed [SMP_W-1:0]  smp_data,
  input  logic                     batch_end,
  output logic                     busy,
  output logic                     batch_err,
  output logic                     out_valid,
  output logic [IDX_W-1:0]         out_idx,
  output logic signed [PROD_W-1:0] out_i,
  output logic signed [PROD_W-1:0] out_q
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  lk_state_e             st_q, st_d;
  logic [IDX_W-1:0]      n_q, n_d, wr_q, wr_d, oidx_q, oidx_d;
  logic                  sign_q, sign_d, ov_q, ov_d, err_q, err_d;
  logic [PH_W-1:0]       ph_q, ph_d;
  logic signed [PROD_W-1:0] oi_q, oi_d, oq_q, oq_d;
  logic signed [SMP_W-1:0]  buf_q [BATCH];

  logic                  idle, smp_we, div_start, div_done, both_valid;
  logic signed [SLOT_W-1:0] newest, oldest;
  logic [SLOT_W-1:0]     age_step, ref_per, n_times_p;
  logic signed [IP_W-1:0] diff, ip;
  logic [IP_W-1:0]       mag;
  logic [PH_W-1:0]       q16, frac;
  logic signed [SMP_W-1:0] sin_w, cos_w, smp_cur;
  logic signed [PROD_W-1:0] prod_i, prod_q;

  assign idle   = (st_q == S_IDLE);
  assign smp_we = idle && smp_valid && !batch_end;

  assign age_step = SLOT_W'(BATCH) * SLOT_W'(cfg_period);

  lockin_ts_track u_track (
    .clk(clk), .rst_n(rst_sn), .ts_valid(ts_valid && idle), .ts_value(ts_value),
    .batch_end(batch_end && idle), .age_step(age_step),
    .newest(newest), .oldest(oldest), .both_valid(both_valid)
  );

  assign ref_per   = newest - oldest;
  assign n_times_p = SLOT_W'(n_q) * SLOT_W'(cfg_period);
  assign diff      = IP_W'(n_times_p) - IP_W'(newest);
  assign ip        = diff * $signed({1'b0, cfg_harm});
  assign mag       = ip[IP_W-1] ? IP_W'(-ip) : IP_W'(ip);

  lockin_div #(.DVD_W(DVD_W), .DVS_W(SLOT_W), .Q_W(PH_W)) u_div (
    .clk(clk), .rst_n(rst_sn), .start(div_start), .dividend({mag, PH_W'(0)}),
    .divisor(ref_per), .done(div_done), .quotient(q16)
  );

  assign frac = sign_q ? PH_W'(0) - q16 : q16;

  lockin_sincos u_lut (.ph_hi(ph_q[PH_W-1 -: LUT_AW+2]), .sin_o(sin_w), .cos_o(cos_w));

  logic unused_ph_lo;
  assign unused_ph_lo = ^ph_q[PH_W-LUT_AW-3:0];

  assign smp_cur = buf_q[n_q];
  assign prod_i  = PROD_W'(sin_w) * PROD_W'(smp_cur);
  assign prod_q  = PROD_W'(cos_w) * PROD_W'(smp_cur);

  always_comb begin
    st_d = st_q; n_d = n_q; wr_d = wr_q; sign_d = sign_q; ph_d = ph_q;
    ov_d = 1'b0; err_d = 1'b0; oidx_d = oidx_q; oi_d = oi_q; oq_d = oq_q;
    div_start = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (batch_end) begin
          st_d = S_CHECK; wr_d = '0;
        end else if (smp_valid) begin
          wr_d = wr_q + 1'b1;
        end
      end
      S_CHECK: begin
        if (both_valid) begin
          st_d = S_START; n_d = '0;
        end else begin
          st_d = S_IDLE; err_d = 1'b1;
        end
      end
      S_START: begin
        div_start = 1'b1; sign_d = ip[IP_W-1]; st_d = S_DIV;
      end
      S_DIV: begin
        if (div_done) begin
          ph_d = cfg_offset + frac; st_d = S_MUL;
        end
      end
      S_MUL: begin
        ov_d = 1'b1; oidx_d = n_q; oi_d = prod_i; oq_d = prod_q;
        if (n_q == IDX_W'(BATCH - 1)) st_d = S_IDLE;
        else begin
          n_d = n_q + 1'b1; st_d = S_START;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= S_IDLE; n_q <= '0; wr_q <= '0; sign_q <= 1'b0; ph_q <= '0;
      ov_q <= 1'b0; err_q <= 1'b0; oidx_q <= '0; oi_q <= '0; oq_q <= '0;
    end else begin
      st_q <= st_d; n_q <= n_d; wr_q <= wr_d; sign_q <= sign_d; ph_q <= ph_d;
      ov_q <= ov_d; err_q <= err_d; oidx_q <= oidx_d; oi_q <= oi_d; oq_q <= oq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (smp_we) buf_q[wr_q] <= smp_data;
  end

  assign busy      = !idle;
  assign batch_err = err_q;
  assign out_valid = ov_q;
  assign out_idx   = oidx_q;
  assign out_i     = oi_q;
  assign out_q     = oq_q;

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0({ov_q, err_q}));
  p_err_src_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    err_q |-> ($past(st_q) == S_CHECK && !$past(both_valid)));
  p_idx_last_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    (ov_q && oidx_q == IDX_W'(BATCH - 1)) |-> idle);
endmodule

// File: tb/lockin_demod_tb.sv
module lockin_demod_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] cfg_offset, cfg_period;
  logic [7:0]  cfg_harm;
  logic        ts_valid, smp_valid, batch_end;
  logic [15:0] ts_value;
  logic signed [15:0] smp_data;
  logic        busy, batch_err, out_valid;
  logic [3:0]  out_idx;
  logic signed [31:0] out_i, out_q;

  always #5 clk = ~clk;

  lockin_demod u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_offset(cfg_offset), .cfg_period(cfg_period),
    .cfg_harm(cfg_harm), .ts_valid(ts_valid), .ts_value(ts_value),
    .smp_valid(smp_valid), .smp_data(smp_data), .batch_end(batch_end),
    .busy(busy), .batch_err(batch_err), .out_valid(out_valid), .out_idx(out_idx),
    .out_i(out_i), .out_q(out_q)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  typedef struct { bit err; int idx; longint x; longint ei; longint eq; } exp_t;
  exp_t expq[$];

  longint m_new, m_old;
  bit     mv_new, mv_old;

  task automatic chk(bit ok, string tag, longint act, longint exv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exv);
    end
  endtask

  // R7 table model
  function automatic longint tsin(int ph);
    int quad = (ph >> 14) & 3;
    int i = (ph >> 8) & 63;
    int k = ((quad & 1) != 0) ? 63 - i : i;
    longint m = longint'($rtoi($floor(32767.0 * $sin(3.141592653589793 * real'(2 * k + 1) / 256.0) + 0.5)));
    return (quad >= 2) ? -m : m;
  endfunction

  task automatic model_batch(input int tsl[$], input int smp[16]);
    int first;
    longint p = cfg_period, h = cfg_harm, r, ipv, mg, q, fr, ph;
    if (mv_new) m_new -= 16 * p;  // R3
    if (mv_old) m_old -= 16 * p;
    first = (tsl.size() > 2) ? tsl.size() - 2 : 0;  // R4
    for (int j = first; j < tsl.size(); j++) begin  // R2
      m_old = m_new; mv_old = mv_new; m_new = tsl[j]; mv_new = 1;
    end
    if (!(mv_new && mv_old)) begin
      expq.push_back('{1, 0, 0, 0, 0});
    end else begin
      r = m_new - m_old;  // R6
      for (int n = 0; n < 16; n++) begin
        ipv = (longint'(n) * p - m_new) * h;
        mg  = (ipv < 0) ? -ipv : ipv;
        q   = (mg <<< 16) / r;
        fr  = q & 65535;
        if (ipv < 0) fr = (65536 - fr) & 65535;
        ph  = (longint'(cfg_offset) + fr) & 65535;
        expq.push_back('{0, n, longint'(smp[n]), tsin(int'(ph)) * smp[n],
                         tsin(int'((ph + 16384) & 65535)) * smp[n]});
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && (out_valid || batch_err)) begin
      if (expq.size() == 0) begin
        chk(0, "R5 unexpected output event", {63'd0, out_valid}, 0);
      end else begin
        exp_t e;
        longint tol, di, dq;
        e = expq.pop_front();
        if (e.err) begin
          chk(batch_err && !out_valid, "R5 error pulse without products", {63'd0, out_valid}, 0);
        end else begin
          tol = (e.x < 0) ? -e.x : e.x;
          di  = longint'(out_i) - e.ei;
          dq  = longint'(out_q) - e.eq;
          chk(out_valid && !batch_err, "R1 product pair expected", {63'd0, batch_err}, 0);
          chk(out_idx == e.idx[3:0], "R1 sample index", longint'(out_idx), e.idx);
          chk(di <= tol && -di <= tol, "R8 in-phase product (R6 phase)", longint'(out_i), e.ei);
          chk(dq <= tol && -dq <= tol, "R8 quadrature product (R7 fold)", longint'(out_q), e.eq);
        end
      end
    end
  end

  task automatic send_batch(input int tsl[$], input int smp[16]);
    foreach (tsl[j]) begin
      ts_valid = 1; ts_value = 16'(tsl[j]); @(negedge clk);
    end
    ts_valid = 0;
    for (int n = 0; n < 16; n++) begin
      smp_valid = 1; smp_data = 16'(smp[n]); @(negedge clk);
    end
    smp_valid = 0;
    batch_end = 1;
    model_batch(tsl, smp);
    @(negedge clk);
    batch_end = 0;
    chk(busy == 1'b1, "R10 busy after batch end", {63'd0, busy}, 1);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic fill(output int s[16], input int seed, input bit extreme);
    for (int n = 0; n < 16; n++)
      s[n] = extreme ? (((n & 1) != 0) ? 32767 : -32768)
                     : ((n * 7919 + seed * 10477) % 65536) - 32768;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    mv_new = 0; mv_old = 0; m_new = 0; m_old = 0;
    // R9 idle outputs after reset
    chk(!busy && !out_valid && !batch_err, "R9 idle after reset",
        {61'd0, busy, out_valid, batch_err}, 0);
  endtask

  initial begin
    int s[16];
    ts_valid = 0; smp_valid = 0; batch_end = 0; ts_value = 0; smp_data = 0;
    cfg_offset = 0; cfg_period = 200; cfg_harm = 1;
    @(negedge clk);
    do_reset();
    fill(s, 1, 0); send_batch('{}, s);                // R5: no edge
    fill(s, 2, 0); send_batch('{200}, s);             // R5: one edge
    fill(s, 3, 0); send_batch('{100}, s);             // R3: aged edge pairs with new one
    fill(s, 4, 0); send_batch('{5, 300, 3100}, s);    // R4: first capture dropped
    fill(s, 5, 0); send_batch('{}, s);                // R3: both slots aged
    cfg_harm = 2; cfg_offset = 16'h1000;
    fill(s, 6, 1); send_batch('{1000}, s);            // R7/R8 full scale
    cfg_period = 150; cfg_harm = 3; cfg_offset = 16'hC123;
    fill(s, 7, 0); send_batch('{0, 2000}, s);         // R6 negative and positive phase
    do_reset();
    fill(s, 8, 0); send_batch('{50}, s);              // R9: slots emptied
    fill(s, 9, 0); send_batch('{900}, s);
    repeat (5) @(negedge clk);
    chk(expq.size() == 0, "R1 all expected events seen", expq.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end
endmodule